// File: doc/BRIEF.md
# Real-Mode Software Interrupt Entry Sequencer

This block carries out the entry into a software interrupt handler for a core running in real-address mode. On a start pulse it captures the vector number together with the current code segment, instruction pointer, flags word, stack segment and stack pointer. It also captures the byte limit of the interrupt table and the count of free stack bytes. It then settles both fault checks before it touches memory.

When both checks pass, the block writes a three-word return frame through a 16-bit write port. It then reads the handler's offset word and selector word from the interrupt table through a 16-bit read port. It ends with a one-cycle done pulse, and at that point the new code segment, instruction pointer, flags and stack pointer are on its result outputs. When a check fails, it gives a one-cycle fault pulse with a kind code and makes no memory request at all. Both memory ports use valid/ready, and either one may stall the sequence for any number of cycles.

Top module: `rm_irq_entry`

## Requirements
- R1: A start pulse while `busy` is low is accepted and `busy` is high in the next cycle. A start pulse while `busy` is high is ignored, so the run in progress completes with the values captured at its own start.
- R2: If vector×4+3 is greater than the table limit, the run ends with a fault pulse whose `fault_kind` is 1 (general protection). A value exactly equal to the limit passes.
- R3: If the table check passes and fewer than 6 stack bytes are free, the run ends with a fault pulse whose `fault_kind` is 2 (stack). When both checks fail, code 1 takes priority.
- R4: A faulting run issues no write and no read, and its result outputs `new_cs`, `new_ip`, `new_flags` and `new_sp` equal the captured CS, IP, FLAGS and SP.
- R5: A passing run issues exactly three writes, in this order: FLAGS[15:0] at SS×16+SP−2, then CS at SS×16+SP−4, then IP at SS×16+SP−6. SP arithmetic wraps at 16 bits and the linear address wraps at 20 bits.
- R6: The pushed FLAGS image carries the old flag values. The resulting `new_flags` equals the captured flags with bits 8 (trap), 9 (interrupt enable) and 18 (alignment check) cleared, and every other bit kept.
- R7: A passing run then issues exactly two reads: the offset word at TABLE_BASE+vector×4 and the selector word at TABLE_BASE+vector×4+2. At done, `new_ip` is the offset word, `new_cs` is the selector word and `new_sp` is SP−6.
- R8: `done` and `fault` are single-cycle pulses that are never high together. `fault_kind` is 0 whenever `fault` is low, and `busy` is low in the cycle after either pulse.
- R9: While a request is valid and not ready, it stays valid with stable address and data.
- R10: At most one of `wr_valid` and `rd_valid` is high in any cycle, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an interrupt entry (accepted when idle) |
| vector | input | VEC_W | Interrupt vector number |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| flags_in | input | 32 | Current flags |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| tbl_limit | input | 16 | Last valid byte offset of the interrupt table |
| stack_free | input | 16 | Bytes available on the stack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_kind | output | 2 | 0 none, 1 general protection, 2 stack |
| new_cs | output | 16 | Resulting code segment |
| new_ip | output | 16 | Resulting instruction pointer |
| new_flags | output | 32 | Resulting flags |
| new_sp | output | 16 | Resulting stack pointer |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 16 | Write data word |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read data returned this cycle |
| rd_addr | output | ADDR_W | Read byte address |
| rd_data | input | 16 | Read data word |

## Verification
The assertions assume that the memory side obeys the handshake: read data is valid in the cycle where `rd_valid` and `rd_ready` are both high, and `wr_ready` does not depend on anything but the bench's own random draw. They also assume `start` is a single-cycle pulse. The bench redraws both ready signals on each falling edge with a chosen stall percentage, drives start for exactly one cycle, and answers reads with a word computed from the address in the same cycle. Captured inputs may then change freely, which the bench does on purpose during a busy run.

// File: rtl/rm_irq_pkg.sv
package rm_irq_pkg;

  localparam int FRAME_BYTES = 6;
  localparam int FL_TRAP  = 8;
  localparam int FL_IEN   = 9;
  localparam int FL_ALIGN = 18;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_GP   = 2'd1,
    FK_SS   = 2'd2
  } fault_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP,
    ST_RD_OFF, ST_RD_SEL, ST_DONE, ST_FAULT
  } seq_state_e;

  // byte offset of the final byte of a 4-byte table entry
  function automatic logic [31:0] entry_last(input logic [31:0] vec);
    return (vec << 2) + 32'd3;
  endfunction

  // real-mode linear address: segment times 16 plus offset
  function automatic logic [31:0] seg_linear(input logic [15:0] seg, input logic [15:0] off);
    return ({16'b0, seg} << 4) + {16'b0, off};
  endfunction

  function automatic logic [31:0] clear_entry_flags(input logic [31:0] f);
    logic [31:0] m;
    m = '0;
    m[FL_TRAP]  = 1'b1;
    m[FL_IEN]   = 1'b1;
    m[FL_ALIGN] = 1'b1;
    return f & ~m;
  endfunction

endpackage

// File: rtl/rm_irq_check.sv
module rm_irq_check
  import rm_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [15:0]      limit,
  input  logic [15:0]      free_bytes,
  output logic             limit_bad,
  output logic             stack_bad
);
  assign limit_bad = entry_last(32'(vec)) > 32'(limit);
  assign stack_bad = 32'(free_bytes) < 32'(FRAME_BYTES);
endmodule

// File: rtl/rm_irq_addr.sv
module rm_irq_addr
  import rm_irq_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int ADDR_W     = 20,
  parameter int TABLE_BASE = 0
) (
  input  logic [15:0]       ss,
  input  logic [15:0]       sp,
  input  logic [1:0]        push_idx,
  input  logic [VEC_W-1:0]  vec,
  input  logic              sel_word,
  output logic [ADDR_W-1:0] st_addr,
  output logic [ADDR_W-1:0] tb_addr
);
  logic [15:0] push_off;
  logic [31:0] tb_lin;

  assign push_off = sp - {13'b0, push_idx, 1'b0};
  assign st_addr  = ADDR_W'(seg_linear(ss, push_off));
  assign tb_lin   = 32'(TABLE_BASE) + (32'(vec) << 2) + (sel_word ? 32'd2 : 32'd0);
  assign tb_addr  = ADDR_W'(tb_lin);
endmodule

// File: rtl/rm_irq_entry.sv
module rm_irq_entry
  import rm_irq_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int ADDR_W     = 20,
  parameter int TABLE_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  vector,
  input  logic [15:0]       cs_in,
  input  logic [15:0]       ip_in,
  input  logic [31:0]       flags_in,
  input  logic [15:0]       ss_in,
  input  logic [15:0]       sp_in,
  input  logic [15:0]       tbl_limit,
  input  logic [15:0]       stack_free,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_kind,
  output logic [15:0]       new_cs,
  output logic [15:0]       new_ip,
  output logic [31:0]       new_flags,
  output logic [15:0]       new_sp,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       rd_data
);

  seq_state_e       state;
  fault_kind_e      kind_q;
  logic [VEC_W-1:0] vec_q;
  logic [15:0]      cs_q, ip_q, ss_q, sp_q, lim_q, free_q;
  logic [31:0]      flags_q;
  logic             checks_ok;

  // named internal events for the checker
  logic limit_bad, stack_bad, wr_fire, rd_fire, accept;
  logic [1:0] push_idx;
  logic [ADDR_W-1:0] st_addr, tb_addr;

  rm_irq_check #(.VEC_W(VEC_W)) u_check (
    .vec(vec_q), .limit(lim_q), .free_bytes(free_q),
    .limit_bad(limit_bad), .stack_bad(stack_bad)
  );

  rm_irq_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE)) u_addr (
    .ss(ss_q), .sp(sp_q), .push_idx(push_idx), .vec(vec_q),
    .sel_word(state == ST_RD_SEL), .st_addr(st_addr), .tb_addr(tb_addr)
  );

  always_comb begin
    unique case (state)
      ST_PUSH_FL: push_idx = 2'd1;
      ST_PUSH_CS: push_idx = 2'd2;
      default:    push_idx = 2'd3;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign accept   = start && !busy;
  assign wr_valid = (state == ST_PUSH_FL) || (state == ST_PUSH_CS) || (state == ST_PUSH_IP);
  assign rd_valid = (state == ST_RD_OFF) || (state == ST_RD_SEL);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_addr  = st_addr;
  assign rd_addr  = tb_addr;
  assign done     = (state == ST_DONE);
  assign fault    = (state == ST_FAULT);
  assign fault_kind = fault ? kind_q : FK_NONE;

  always_comb begin
    unique case (state)
      ST_PUSH_FL: wr_data = flags_q[15:0];
      ST_PUSH_CS: wr_data = cs_q;
      default:    wr_data = ip_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind_q    <= FK_NONE;
      checks_ok <= 1'b0;
      vec_q <= '0; cs_q <= '0; ip_q <= '0; ss_q <= '0; sp_q <= '0;
      lim_q <= '0; free_q <= '0; flags_q <= '0;
      new_cs <= '0; new_ip <= '0; new_flags <= '0; new_sp <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          vec_q <= vector; cs_q <= cs_in; ip_q <= ip_in; ss_q <= ss_in;
          sp_q <= sp_in; lim_q <= tbl_limit; free_q <= stack_free;
          flags_q <= flags_in;
          // results start as the unchanged state
          new_cs <= cs_in; new_ip <= ip_in; new_flags <= flags_in; new_sp <= sp_in;
          kind_q <= FK_NONE;
          state  <= ST_CHECK;
        end
        ST_CHECK: begin
          if (limit_bad) begin
            kind_q <= FK_GP;
            state  <= ST_FAULT;
          end else if (stack_bad) begin
            kind_q <= FK_SS;
            state  <= ST_FAULT;
          end else begin
            checks_ok <= 1'b1;
            state     <= ST_PUSH_FL;
          end
        end
        ST_PUSH_FL: if (wr_fire) begin
          new_flags <= clear_entry_flags(flags_q);
          state     <= ST_PUSH_CS;
        end
        ST_PUSH_CS: if (wr_fire) state <= ST_PUSH_IP;
        ST_PUSH_IP: if (wr_fire) begin
          new_sp <= sp_q - 16'(FRAME_BYTES);
          state  <= ST_RD_OFF;
        end
        ST_RD_OFF: if (rd_fire) begin
          new_ip <= rd_data;
          state  <= ST_RD_SEL;
        end
        ST_RD_SEL: if (rd_fire) begin
          new_cs <= rd_data;
          state  <= ST_DONE;
        end
        ST_DONE: begin
          checks_ok <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rm_irq_entry_chk.sv
module rm_irq_entry_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [1:0]        fault_kind,
  input logic [31:0]       new_flags,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              checks_ok
);

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid && !rd_valid);

  a_r4_checks_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || rd_valid) |-> checks_ok);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault && !busy);

  a_r8_kind_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> fault_kind == 2'd0);

  a_r8_kind_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_kind == 2'd1 || fault_kind == 2'd2));

  a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !new_flags[8] && !new_flags[9] && !new_flags[18]);

endmodule

bind rm_irq_entry rm_irq_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .fault_kind(fault_kind), .new_flags(new_flags),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .checks_ok(checks_ok)
);

// File: tb/rm_irq_entry_test.sv
`timescale 1ns/1ps
module rm_irq_entry_test;

  localparam int VEC_W = 8;
  localparam int ADDR_W = 20;
  localparam int TBASE = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VEC_W-1:0] vector = '0;
  logic [15:0] cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0, tbl_limit = '0, stack_free = '0;
  logic [31:0] flags_in = '0;
  logic busy, done, fault;
  logic [1:0] fault_kind;
  logic [15:0] new_cs, new_ip, new_sp;
  logic [31:0] new_flags;
  logic wr_valid, rd_valid;
  logic wr_ready = 1'b0, rd_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;

  int checks = 0;
  int fails = 0;
  int stall_pct = 0;
  int nwr = 0, nrd = 0;
  logic [ADDR_W-1:0] wa [8];
  logic [15:0]       wd [8];
  logic [ADDR_W-1:0] ra [8];
  int cycles = 0;

  always #10 clk = ~clk; // 50 MHz

  rm_irq_entry #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .TABLE_BASE(TBASE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector),
    .cs_in(cs_in), .ip_in(ip_in), .flags_in(flags_in), .ss_in(ss_in), .sp_in(sp_in),
    .tbl_limit(tbl_limit), .stack_free(stack_free),
    .busy(busy), .done(done), .fault(fault), .fault_kind(fault_kind),
    .new_cs(new_cs), .new_ip(new_ip), .new_flags(new_flags), .new_sp(new_sp),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] mem_word(input logic [ADDR_W-1:0] a);
    logic [15:0] x;
    x = a[15:0] * 16'h9E37;
    return x ^ {12'h5A5, a[19:16]};
  endfunction

  function automatic logic [ADDR_W-1:0] lin(input logic [15:0] seg, input logic [15:0] off);
    int unsigned s;
    s = int'(seg) * 16 + int'(off);
    return s[ADDR_W-1:0];
  endfunction

  assign rd_data = mem_word(rd_addr);

  always @(negedge clk) begin
    wr_ready = ($urandom % 100) >= stall_pct;
    rd_ready = ($urandom % 100) >= stall_pct;
  end

  always @(posedge clk) begin
    if (wr_valid && wr_ready && nwr < 8) begin wa[nwr] = wr_addr; wd[nwr] = wr_data; nwr++; end
    if (rd_valid && rd_ready && nrd < 8) begin ra[nrd] = rd_addr; nrd++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [7:0] v, input logic [15:0] cs, input logic [15:0] ip,
                     input logic [31:0] fl, input logic [15:0] ss, input logic [15:0] sp,
                     input logic [15:0] lim, input logic [15:0] fr, input bit poke);
    bit gp, sf;
    int cyc;
    logic [1:0] ek;
    logic [31:0] efl;
    logic [ADDR_W-1:0] tb;
    @(negedge clk);
    nwr = 0; nrd = 0;
    vector = v; cs_in = cs; ip_in = ip; flags_in = fl; ss_in = ss; sp_in = sp;
    tbl_limit = lim; stack_free = fr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R1", "busy after start", 32'(busy), 1);
    if (poke) begin
      vector = ~v; cs_in = ~cs; ip_in = ~ip; flags_in = ~fl; sp_in = sp + 16'd40;
      tbl_limit = 16'hFFFF; stack_free = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!(done || fault) && cyc < 500) begin @(negedge clk); cyc++; end
    gp = (int'(v) * 4 + 3) > int'(lim);
    sf = !gp && (fr < 16'd6);
    ek = gp ? 2'd1 : (sf ? 2'd2 : 2'd0);
    chk(fault === (gp || sf), gp ? "R2" : "R3", "fault pulse", 32'(fault), 32'(gp || sf));
    chk(done === !(gp || sf), "R8", "done pulse", 32'(done), 32'(!(gp || sf)));
    chk(fault_kind === ek, gp ? "R2" : "R3", "fault_kind", 32'(fault_kind), 32'(ek));
    if (gp || sf) begin
      chk(nwr == 0 && nrd == 0, "R4", "no memory traffic", 32'(nwr + nrd), 0);
      chk(new_cs === cs && new_ip === ip && new_sp === sp, "R4", "cs/ip/sp kept",
          {new_cs, new_ip}, {cs, ip});
      chk(new_flags === fl, "R4", "flags kept", new_flags, fl);
    end else begin
      chk(nwr == 3, "R5", "write count", 32'(nwr), 3);
      chk(wa[0] === lin(ss, sp - 16'd2) && wd[0] === fl[15:0], "R6", "flags image pushed first",
          {12'b0, wa[0]}, {12'b0, lin(ss, sp - 16'd2)});
      chk(wd[0] === fl[15:0], "R6", "pushed flags old value", 32'(wd[0]), 32'(fl[15:0]));
      chk(wa[1] === lin(ss, sp - 16'd4) && wd[1] === cs, "R5", "cs push",
          {wa[1][15:0], wd[1]}, {lin(ss, sp - 16'd4)[15:0], cs});
      chk(wa[2] === lin(ss, sp - 16'd6) && wd[2] === ip, "R5", "ip push",
          {wa[2][15:0], wd[2]}, {lin(ss, sp - 16'd6)[15:0], ip});
      tb = ADDR_W'(TBASE + int'(v) * 4);
      chk(nrd == 2 && ra[0] === tb && ra[1] === tb + 20'd2, "R7", "table reads",
          {12'b0, ra[0]}, {12'b0, tb});
      chk(new_ip === mem_word(tb), "R7", "new_ip", 32'(new_ip), 32'(mem_word(tb)));
      chk(new_cs === mem_word(tb + 20'd2), "R7", "new_cs", 32'(new_cs), 32'(mem_word(tb + 20'd2)));
      chk(new_sp === sp - 16'd6, "R7", "new_sp", 32'(new_sp), 32'(sp - 16'd6));
      efl = fl;
      efl[8] = 1'b0; efl[9] = 1'b0; efl[18] = 1'b0;
      chk(new_flags === efl, "R6", "new_flags", new_flags, efl);
    end
    if (poke) chk(new_sp !== sp + 16'd34 && (gp || sf || nwr == 3), "R1",
                  "start while busy ignored", 32'(nwr), 3);
    @(negedge clk);
    chk(!done && !fault && !busy && fault_kind == 2'd0, "R8", "pulse ends",
        {29'b0, done, fault, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !wr_valid && !rd_valid, "R10", "reset quiet",
        {27'b0, busy, done, fault, wr_valid, rd_valid}, 0);
    rst_n = 1'b1;
    void'($urandom(32'h1A2B3C));
    // directed corners
    stall_pct = 0;
    run(8'h10, 16'h1234, 16'h0100, 32'h0004_0302, 16'h2000, 16'h0100, 16'h0043, 16'd6, 0);
    run(8'h10, 16'h1234, 16'h0100, 32'h0004_0302, 16'h2000, 16'h0100, 16'h0042, 16'd6, 0);
    run(8'h10, 16'h1234, 16'h0100, 32'h0004_0302, 16'h2000, 16'h0100, 16'h03FF, 16'd5, 0);
    run(8'hFF, 16'h1234, 16'h0100, 32'h0004_0302, 16'h2000, 16'h0100, 16'h0010, 16'd0, 0);
    run(8'h00, 16'hAAAA, 16'h5555, 32'hFFFF_FFFF, 16'hFFFF, 16'h0000, 16'h0003, 16'd6, 0);
    stall_pct = 70;
    run(8'h21, 16'hBEEF, 16'hCAFE, 32'h0000_0200, 16'h0800, 16'hFFF0, 16'h03FF, 16'd100, 1);
    run(8'h05, 16'h0001, 16'h0002, 32'h0004_0100, 16'h0010, 16'h0002, 16'h0000, 16'd9, 1);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [7:0] v;
      logic [15:0] lim, fr;
      stall_pct = int'($urandom % 60);
      v = 8'($urandom);
      lim = ($urandom % 8 == 0) ? 16'(int'(v) * 4 + 2 - int'($urandom % 3)) : 16'h03FF;
      fr  = 16'($urandom % 12);
      run(v, 16'($urandom), 16'($urandom), $urandom, 16'($urandom), 16'($urandom),
          lim, fr, ($urandom % 5) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule